// File: doc/BRIEF.md
# Duty-Cycled Temperature Protection Monitor

This block watches battery-pack temperature through an external thermistor divider. The divider is only powered during a short measurement window that repeats at a much longer period, and the block drives that power enable. Four comparators look at the divider. Their digital results arrive as two flags per limit: a detect flag, set when the temperature is past the trip point, and a release flag, set when the temperature is past the recovery point. The block samples the flags once per window and qualifies each limit over elapsed time. It then reports a charge inhibit and a discharge inhibit caused by temperature.

In the intended configuration the window is 16 ms and the period is 2.68 s. A fault must persist for 2.048 s before it is raised and must be absent for 100 ms before it is dropped. The discharge hot limit trips at 75 °C and recovers at 65 °C. The charge hot limit trips at 50 °C and recovers at 40 °C. The charge cold limit trips at 0 °C and recovers at 10 °C. The block also drives a 2-bit status code toward a chained protection device. That code separates normal operation, a voltage-related shut-off, and a temperature fault.

Top module: `thermal_guard`

## Requirements
- R1: While `en_i` is high, `sense_o` is high during the first WINDOW_CYC cycles of every PERIOD_CYC-cycle frame, counted from reset release, and low for the rest of the frame. `sense_o` is low whenever `en_i` is low.
- R2: Flags are captured only in the last cycle of the window. The captured value is the one present at the clock edge where `sense_o` falls. A flag that is high only while `sense_o` is low has no effect on the inhibits.
- R3: A limit that is not faulted becomes faulted when its captured detect flag has been high for DETECT_CYC cycles, counted from the capture edge. The fault shows DETECT_CYC cycles after that edge. A later capture of a low detect flag restarts the count.
- R4: A faulted limit clears when its captured release flag has been low for RELEASE_CYC cycles, counted from the capture edge. The clear shows RELEASE_CYC cycles after that edge.
- R5: Hysteresis applies to each limit. A faulted limit stays faulted while its captured release flag is high, even if its detect flag is low. A limit that is not faulted never faults while its detect flag is low.
- R6: Flag bit positions in `det_i` and `rel_i` are: bit 0 charge hot, bit 1 charge cold, bit 2 discharge hot, bit 3 discharge cold. `chg_inh_o` is the OR of the faults on bits 0 and 1. `dsg_inh_o` is the OR of the faults on bits 2 and 3.
- R7: `casc_o` is 2'b10 while either inhibit is high. Otherwise it is 2'b00 while `volt_off_i` is high, and 2'b01 when neither condition holds. The value 2'b11 never appears.
- R8: While `en_i` is low, all faults, timers and captured flags are cleared. Both inhibits are low from the cycle after `en_i` goes low and stay low for as long as it stays low.
- R9: After reset both inhibits are low, captured flags are clear, and the frame counter starts at the first window cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Temperature protection enable |
| det_i | input | 4 | Detect-threshold comparator flags, one per limit |
| rel_i | input | 4 | Release-threshold comparator flags, one per limit |
| volt_off_i | input | 1 | Voltage-fault shut-off request for the status code |
| sense_o | output | 1 | Thermistor divider enable (measurement window) |
| chg_inh_o | output | 1 | Charge inhibit from temperature |
| dsg_inh_o | output | 1 | Discharge inhibit from temperature |
| casc_o | output | 2 | Status code toward the chained device |

## Verification
The bench toggles a flag only outside the window. A design that samples continuously would then raise a fault from readings the thermistor never made. It measures the exact cycle on which a fault sets and clears relative to the capture edge. An off-by-one timer, or a design that counts windows instead of cycles, shows up as a mismatch there. It parks a faulted limit between the release and detect thresholds. A design without hysteresis would drop the inhibit in that band. It also removes the enable while a fault is active and while flags are asserted. A design that merely masks the output would keep stale state and re-assert an inhibit as soon as the enable returns.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    CASC_OFF    = 2'b00,
    CASC_NORMAL = 2'b01,
    CASC_TEMP   = 2'b10
  } casc_code_e;

  localparam int unsigned NUM_LIMITS   = 4;
  localparam int unsigned LIM_CHG_HOT  = 0;
  localparam int unsigned LIM_CHG_COLD = 1;
  localparam int unsigned LIM_DSG_HOT  = 2;
  localparam int unsigned LIM_DSG_COLD = 3;

  // temperature fault outranks voltage shut-off
  function automatic casc_code_e casc_encode(input logic temp_fault, input logic volt_off);
    if (temp_fault)    return CASC_TEMP;
    else if (volt_off) return CASC_OFF;
    else               return CASC_NORMAL;
  endfunction
endpackage

// File: rtl/tg_window_timer.sv
module tg_window_timer #(
  parameter int unsigned PERIOD_CYC = 2680,
  parameter int unsigned WINDOW_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sense_o,
  output logic sample_o
);
  localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          last_cyc;

  assign last_cyc = (cnt_q == CW'(PERIOD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (last_cyc) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign sense_o  = en_i & (cnt_q < CW'(WINDOW_CYC));
  assign sample_o = en_i & (cnt_q == CW'(WINDOW_CYC - 1));
endmodule

// File: rtl/tg_limit_qual.sv
module tg_limit_qual #(
  parameter int unsigned DETECT_CYC  = 2048,
  parameter int unsigned RELEASE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sample_i,
  input  logic det_i,
  input  logic rel_i,
  output logic fault_o
);
  localparam int unsigned MAXC = (DETECT_CYC > RELEASE_CYC) ? DETECT_CYC : RELEASE_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  logic          det_q, rel_q, fault_q;
  logic [TW-1:0] tmr_q;
  logic          cond;
  logic [TW-1:0] lim;

  // faulted: wait for release flag to drop; idle: wait for detect flag
  assign cond = fault_q ? ~rel_q : det_q;
  assign lim  = fault_q ? TW'(RELEASE_CYC - 1) : TW'(DETECT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q   <= 1'b0;
      rel_q   <= 1'b0;
      fault_q <= 1'b0;
      tmr_q   <= '0;
    end else if (!en_i) begin
      det_q   <= 1'b0;
      rel_q   <= 1'b0;
      fault_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      if (sample_i) begin
        det_q <= det_i;
        rel_q <= rel_i;
      end
      if (!cond) begin
        tmr_q <= '0;
      end else if (tmr_q == lim) begin
        tmr_q   <= '0;
        fault_q <= ~fault_q;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import tg_pkg::*;
#(
  parameter int unsigned PERIOD_CYC  = 2680,
  parameter int unsigned WINDOW_CYC  = 16,
  parameter int unsigned DETECT_CYC  = 2048,
  parameter int unsigned RELEASE_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [3:0] det_i,
  input  logic [3:0] rel_i,
  input  logic       volt_off_i,
  output logic       sense_o,
  output logic       chg_inh_o,
  output logic       dsg_inh_o,
  output logic [1:0] casc_o
);
  logic                  sample;
  logic [NUM_LIMITS-1:0] fault;
  casc_code_e            casc;

  tg_window_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .WINDOW_CYC(WINDOW_CYC)
  ) i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .sense_o (sense_o),
    .sample_o(sample)
  );

  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_limit
    tg_limit_qual #(
      .DETECT_CYC (DETECT_CYC),
      .RELEASE_CYC(RELEASE_CYC)
    ) i_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .sample_i(sample),
      .det_i   (det_i[g]),
      .rel_i   (rel_i[g]),
      .fault_o (fault[g])
    );
  end

  assign chg_inh_o = fault[LIM_CHG_HOT] | fault[LIM_CHG_COLD];
  assign dsg_inh_o = fault[LIM_DSG_HOT] | fault[LIM_DSG_COLD];
  assign casc      = casc_encode(chg_inh_o | dsg_inh_o, volt_off_i);
  assign casc_o    = casc;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int unsigned PERIOD_CYC  = 2680,
  parameter int unsigned WINDOW_CYC  = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       volt_off_i,
  input logic       sense_o,
  input logic       chg_inh_o,
  input logic       dsg_inh_o,
  input logic [1:0] casc_o
);
  localparam int unsigned RW = $clog2(PERIOD_CYC + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (sense_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R1
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_o |-> run_q < RW'(WINDOW_CYC));

  // R8
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!chg_inh_o && !dsg_inh_o));

  // R3
  chg_rise_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_inh_o) |-> $past(en_i));

  // R3
  dsg_rise_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsg_inh_o) |-> $past(en_i));

  // R7
  casc_temp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_inh_o || dsg_inh_o) |-> casc_o == 2'b10);

  // R7
  casc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_inh_o && !dsg_inh_o && volt_off_i) |-> casc_o == 2'b00);

  // R7
  casc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_o != 2'b11);
endmodule

bind thermal_guard tg_checker #(
  .PERIOD_CYC(PERIOD_CYC),
  .WINDOW_CYC(WINDOW_CYC)
) i_tg_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .volt_off_i(volt_off_i),
  .sense_o   (sense_o),
  .chg_inh_o (chg_inh_o),
  .dsg_inh_o (dsg_inh_o),
  .casc_o    (casc_o)
);

// File: tb/test_thermal_guard.sv
`timescale 1ns/1ps
module test_thermal_guard;
  localparam int P  = 40;
  localparam int W  = 4;
  localparam int D  = 100;
  localparam int RL = 30;
  localparam int WD_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [3:0] det = '0;
  logic [3:0] rel = '0;
  logic       volt_off = 1'b0;
  logic       sense, chg_inh, dsg_inh;
  logic [1:0] casc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_guard #(
    .PERIOD_CYC(P), .WINDOW_CYC(W), .DETECT_CYC(D), .RELEASE_CYC(RL)
  ) i_thermal_guard (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .det_i(det), .rel_i(rel),
    .volt_off_i(volt_off), .sense_o(sense), .chg_inh_o(chg_inh),
    .dsg_inh_o(dsg_inh), .casc_o(casc)
  );

  // reference model built from the requirements
  int m_cnt;
  int m_tmr [4];
  bit m_hdet [4];
  bit m_hrel [4];
  bit m_fault [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int k = 0; k < 4; k++) begin
        m_tmr[k] = 0; m_hdet[k] = 0; m_hrel[k] = 0; m_fault[k] = 0;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (!en) begin
          m_tmr[k] = 0; m_hdet[k] = 0; m_hrel[k] = 0; m_fault[k] = 0;
        end else begin
          bit c;
          int lim;
          c   = m_fault[k] ? !m_hrel[k] : m_hdet[k];
          lim = m_fault[k] ? RL : D;
          if (!c) m_tmr[k] = 0;
          else if (m_tmr[k] == lim - 1) begin m_tmr[k] = 0; m_fault[k] = !m_fault[k]; end
          else m_tmr[k]++;
          if (m_cnt == W - 1) begin m_hdet[k] = det[k]; m_hrel[k] = rel[k]; end
        end
      end
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  function automatic logic [1:0] exp_casc(bit c, bit d, bit v);
    if (c || d) return 2'b10;
    if (v)      return 2'b00;
    return 2'b01;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ec, ed;
      #1;
      ec = m_fault[0] | m_fault[1];
      ed = m_fault[2] | m_fault[3];
      check("R1 sense window", sense, 32'(en && (m_cnt < W)));
      check("R3/R4/R6 chg_inh model", chg_inh, 32'(ec));
      check("R3/R4/R6 dsg_inh model", dsg_inh, 32'(ed));
      check("R7 casc model", casc, 32'(exp_casc(ec, ed, volt_off)));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns just after the capture edge (sense has fallen)
  task automatic wait_sample();
    bit was;
    was = 0;
    forever begin
      @(negedge clk); #2;
      if (was && !sense) break;
      was = sense;
    end
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int zone [4];
    void'($urandom(32'd20241));
    step(3);
    rst_n = 1'b1;
    #2;
    // R9 reset state
    check("R9 chg_inh after reset", chg_inh, 0);
    check("R9 dsg_inh after reset", dsg_inh, 0);
    check("R9 casc after reset", casc, 2'b01);
    check("R9 sense at frame start", sense, 1);

    // R2 flag only outside window
    for (int i = 0; i < 6; i++) begin
      wait_sample();
      det[0] = 1; rel[0] = 1;
      step(P - W - 2);
      det[0] = 0; rel[0] = 0;
    end
    step(2); #2;
    check("R2 off-window flag ignored", chg_inh, 0);

    // R5 idle limit between thresholds never faults
    rel[1] = 1;
    step(3 * D); #2;
    check("R5 no fault from release flag alone", chg_inh, 0);
    rel[1] = 0;
    step(2 * P);

    // R3 exact detect timing on charge hot
    det[0] = 1; rel[0] = 1;
    wait_sample();
    step(D - 1); #2;
    check("R3 before detect delay", chg_inh, 0);
    step(1); #2;
    check("R3 at detect delay", chg_inh, 1);
    // R6 routing
    check("R6 dsg unaffected by charge limit", dsg_inh, 0);
    check("R7 temp code", casc, 2'b10);

    // R5 hysteresis band holds fault
    det[0] = 0;
    step(4 * P); #2;
    check("R5 fault held in band", chg_inh, 1);

    // R4 exact release timing
    rel[0] = 0;
    wait_sample();
    step(RL - 1); #2;
    check("R4 before release delay", chg_inh, 1);
    step(1); #2;
    check("R4 at release delay", chg_inh, 0);

    // R7 voltage shut-off code
    volt_off = 1;
    step(1); #2;
    check("R7 off code", casc, 2'b00);
    volt_off = 0;

    // R6 discharge cold route
    det[3] = 1; rel[3] = 1;
    wait_sample();
    step(D); #2;
    check("R6 dsg from discharge cold", dsg_inh, 1);
    check("R6 chg clear for discharge limit", chg_inh, 0);

    // R8 disable clears and holds
    en = 0;
    step(1); #2;
    check("R8 inhibit cleared", dsg_inh, 0);
    check("R8 sense off", sense, 0);
    step(3 * D); #2;
    check("R8 inhibit stays low", dsg_inh, 0);
    en = 1;
    step(P); #2;
    check("R8 no stale fault on re-enable", dsg_inh, 0);
    det[3] = 0; rel[3] = 0;
    step(2 * P);

    // constrained random phase
    for (int k = 0; k < 4; k++) zone[k] = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if ($urandom_range(149) == 0) zone[k] = $urandom_range(2);
        det[k] = (zone[k] == 2);
        rel[k] = (zone[k] >= 1);
      end
      if ($urandom_range(99) == 0) volt_off = ~volt_off;
      if (!en) en = ($urandom_range(3) == 0);
      else if ($urandom_range(699) == 0) en = 0;
    end
    step(2); #2;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule